// File: doc/BRIEF.md
# Dual-Bank Interrupt Aggregator with Shadow Routing

This block collects forty level-sensitive interrupt inputs and folds them into one request line toward a primary processor. Software works through a small 32-bit register port. It enables sources through two enable (mask) registers and reads the live causes through two pending registers. Sources 0 to 31 sit in a low bank. Sources 32 to 39 sit in a high bank at a separate, higher offset. A set mask bit enables its source.

A build-time table can pair a primary source with a shadow index. The shadow index has no input of its own. Its pending bit repeats the paired source's level, gated by the shadow's own mask bit. All shadow indices together drive a second request line toward a second processor. Each processor can therefore enable or disable the same event on its own.

A registered index output names the highest-numbered enabled primary source that is pending, so handlers can service causes from the top down. Software clears a cause at the interrupting device. When the input level falls, the pending bit follows it.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset every mask bit is 0, both pending registers read 0 whatever the inputs are, `irqCpu0`, `irqCpu1` and `topValid` are 0, and `topIdx` is 0.
- R2: A write to offset 0x04 loads the masks of sources 0-31 (bit n is source n). A write to offset 0x50 loads the masks of sources 32-39 from data bits 7:0 (bit n is source 32+n). Reading those offsets returns the masks, and bits 31:8 of offset 0x50 read as 0.
- R3: Offset 0x08 returns the pending bits of sources 0-31 and offset 0x54 returns those of sources 32-39 in bits 7:0. A pending bit is the synchronized level ANDed with its mask bit, so a masked source reads 0.
- R4: Pending bits are level-sensitive. A pending bit sets when its input is high and clears by itself once the input falls. Nothing in the block holds it.
- R5: `irqCpu0` is 1 exactly when any primary (non-shadow) pending bit is 1.
- R6: For a source paired with a shadow index (default pairs: 3 with 35, 10 with 38), the shadow's pending bit equals the paired source's level ANDed with the shadow's mask bit. The input wire at a shadow index is ignored. `irqCpu1` is 1 exactly when any shadow pending bit is 1.
- R7: `topIdx` gives the highest-numbered pending primary source and `topValid` flags that one exists. Both are registered one cycle behind the pending bits, and `topIdx` is 0 while `topValid` is 0.
- R8: Writes to any offset other than 0x04 and 0x50 change no mask, and reads of unmapped offsets return 0.
- R9: Writing 0 to both mask registers disables every source and drops both request lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLevel | input | 40 | Raw interrupt levels, one per source index |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for the read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the offset presented on the previous cycle |
| irqCpu0 | output | 1 | Request to the primary processor |
| irqCpu1 | output | 1 | Request to the second processor (shadow indices) |
| topIdx | output | 6 | Highest pending primary source |
| topValid | output | 1 | `topIdx` holds a real source |

## Verification
On every cycle the assertions check four things: each mask write lands in the correct bank, writes to other offsets leave the masks unchanged, no pending bit exists without the mask bit of the previous cycle, and `topValid` trails the primary request by exactly one cycle. They also check that quiet inputs never raise either request line once the synchronizer has drained. Only the bench scenarios can show the full shadow routing: that the level of source 3 reaches index 35 and the raw wire at 35 is ignored. The scenarios also cover the high-bank readback that drops the upper data bits and the top-down index selection across both banks.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC = 40;
  localparam int LO_W = 32;
  localparam int HI_W = NUM_SRC - LO_W;
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam logic [7:0] NO_SHADOW = 8'hFF;

  localparam int OFF_MASK_LO = 'h04;
  localparam int OFF_PEND_LO = 'h08;
  localparam int OFF_MASK_HI = 'h50;
  localparam int OFF_PEND_HI = 'h54;

  typedef logic [7:0] shadow_map_t [NUM_SRC];

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASK_LO, SEL_MASK_HI, SEL_PEND_LO, SEL_PEND_HI
  } rd_sel_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic wrMaskLo;
    logic wrMaskHi;
    logic [31:0] wrData;
  } ctrl_strobe_t;

  function automatic shadow_map_t defaultShadowMap();
    shadow_map_t m;
    for (int j = 0; j < NUM_SRC; j++) m[j] = NO_SHADOW;
    m[3] = 8'd35;
    m[10] = 8'd38;
    return m;
  endfunction

  // set of indices that act as shadows of some primary source
  function automatic logic [NUM_SRC-1:0] shadowSet(shadow_map_t m);
    logic [NUM_SRC-1:0] s;
    s = '0;
    for (int j = 0; j < NUM_SRC; j++)
      if (m[j] != NO_SHADOW && int'(m[j]) < NUM_SRC) s[m[j]] = 1'b1;
    return s;
  endfunction

  // the source whose level feeds index i (itself unless i is a shadow)
  function automatic int ownerOf(shadow_map_t m, int i);
    int o;
    o = i;
    for (int j = 0; j < NUM_SRC; j++)
      if (m[j] != NO_SHADOW && int'(m[j]) == i) o = j;
    return o;
  endfunction
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0] wrData,
  input  logic [intc_pkg::NUM_SRC-1:0] maskVec,
  input  logic [intc_pkg::NUM_SRC-1:0] pendVec,
  output intc_pkg::ctrl_strobe_t strobe,
  output logic [31:0] rdData
);
  import intc_pkg::*;

  rd_sel_t sel;

  always_comb begin
    if (addr == ADDR_W'(OFF_MASK_LO)) sel = SEL_MASK_LO;
    else if (addr == ADDR_W'(OFF_MASK_HI)) sel = SEL_MASK_HI;
    else if (addr == ADDR_W'(OFF_PEND_LO)) sel = SEL_PEND_LO;
    else if (addr == ADDR_W'(OFF_PEND_HI)) sel = SEL_PEND_HI;
    else sel = SEL_NONE;
  end

  always_comb begin
    strobe.wrMaskLo = wrEn && (sel == SEL_MASK_LO);
    strobe.wrMaskHi = wrEn && (sel == SEL_MASK_HI);
    strobe.wrData = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      unique case (sel)
        SEL_MASK_LO: rdData <= maskVec[LO_W-1:0];
        SEL_MASK_HI: rdData <= 32'(maskVec[NUM_SRC-1:LO_W]);
        SEL_PEND_LO: rdData <= pendVec[LO_W-1:0];
        SEL_PEND_HI: rdData <= 32'(pendVec[NUM_SRC-1:LO_W]);
        default:     rdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath #(
  parameter int SYNC_STAGES = 2,
  parameter intc_pkg::shadow_map_t SHADOW_MAP = intc_pkg::defaultShadowMap()
) (
  input  logic clk,
  input  logic rstN,
  input  logic [intc_pkg::NUM_SRC-1:0] srcLevel,
  input  intc_pkg::ctrl_strobe_t strobe,
  output logic [intc_pkg::NUM_SRC-1:0] maskVec,
  output logic [intc_pkg::NUM_SRC-1:0] pendVec,
  output logic irqCpu0,
  output logic irqCpu1,
  output logic [intc_pkg::IDX_W-1:0] topIdx,
  output logic topValid
);
  import intc_pkg::*;

  localparam logic [NUM_SRC-1:0] SHADOW_BITS = shadowSet(SHADOW_MAP);
  localparam logic [NUM_SRC-1:0] PRIMARY_BITS = ~SHADOW_BITS;

  logic [NUM_SRC-1:0] syncPipe [SYNC_STAGES];
  logic [NUM_SRC-1:0] effLevel;
  logic [NUM_SRC-1:0] primPend;
  logic [IDX_W-1:0] nextIdx;
  logic nextValid;

  // input synchronizer chain
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= '0;
    end else begin
      syncPipe[0] <= srcLevel;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end

  // shadow indices take the level of their owning source
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_route
    localparam int OWNER = ownerOf(SHADOW_MAP, i);
    assign effLevel[i] = syncPipe[SYNC_STAGES-1][OWNER];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskVec <= '0;
    end else begin
      if (strobe.wrMaskLo) maskVec[LO_W-1:0] <= strobe.wrData;
      if (strobe.wrMaskHi) maskVec[NUM_SRC-1:LO_W] <= strobe.wrData[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendVec <= '0;
    else pendVec <= effLevel & maskVec;
  end

  assign primPend = pendVec & PRIMARY_BITS;
  assign irqCpu0 = |primPend;
  assign irqCpu1 = |(pendVec & SHADOW_BITS);

  // highest-numbered pending primary wins
  always_comb begin
    nextIdx = '0;
    nextValid = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (primPend[i]) begin
        nextIdx = IDX_W'(i);
        nextValid = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topIdx <= '0;
      topValid <= 1'b0;
    end else begin
      topIdx <= nextIdx;
      topValid <= nextValid;
    end
  end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc #(
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter intc_pkg::shadow_map_t SHADOW_MAP = intc_pkg::defaultShadowMap()
) (
  input  logic clk,
  input  logic rstN,
  input  logic [intc_pkg::NUM_SRC-1:0] srcLevel,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic irqCpu0,
  output logic irqCpu1,
  output logic [intc_pkg::IDX_W-1:0] topIdx,
  output logic topValid
);
  intc_pkg::ctrl_strobe_t strobe;
  logic [intc_pkg::NUM_SRC-1:0] maskVec;
  logic [intc_pkg::NUM_SRC-1:0] pendVec;

  intc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .maskVec(maskVec), .pendVec(pendVec), .strobe(strobe), .rdData(rdData)
  );

  intc_datapath #(.SYNC_STAGES(SYNC_STAGES), .SHADOW_MAP(SHADOW_MAP)) u_dp (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .strobe(strobe),
    .maskVec(maskVec), .pendVec(pendVec), .irqCpu0(irqCpu0),
    .irqCpu1(irqCpu1), .topIdx(topIdx), .topValid(topValid)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rstN,
  input logic [intc_pkg::NUM_SRC-1:0] srcLevel,
  input logic wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0] wrData,
  input logic [intc_pkg::NUM_SRC-1:0] maskVec,
  input logic [intc_pkg::NUM_SRC-1:0] pendVec,
  input logic irqCpu0,
  input logic irqCpu1,
  input logic topValid
);
  import intc_pkg::*;

  localparam int QUIET_W = $clog2(SYNC_STAGES + 3) + 1;
  logic [QUIET_W-1:0] quietCnt;

  always_ff @(posedge clk) begin
    if (!rstN) quietCnt <= '0;
    else if (srcLevel != '0) quietCnt <= '0;
    else if (quietCnt <= QUIET_W'(SYNC_STAGES + 1)) quietCnt <= quietCnt + 1'b1;
  end

  // R2
  mask_lo_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFF_MASK_LO)) |=> maskVec[LO_W-1:0] == $past(wrData));

  // R2
  mask_hi_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFF_MASK_HI)) |=> maskVec[NUM_SRC-1:LO_W] == $past(wrData[HI_W-1:0]));

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr != ADDR_W'(OFF_MASK_LO) && addr != ADDR_W'(OFF_MASK_HI)) |=> $stable(maskVec));

  // R3
  pend_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec & ~$past(maskVec)) == '0);

  // R7
  top_valid_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    topValid == $past(irqCpu0));

  // R4
  quiet_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt > QUIET_W'(SYNC_STAGES + 1)) |-> (!irqCpu0 && !irqCpu1));
endmodule

bind dual_bank_intc intc_checker #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .maskVec(maskVec), .pendVec(pendVec), .irqCpu0(irqCpu0),
  .irqCpu1(irqCpu1), .topValid(topValid)
);

// File: tb/dual_bank_intc_bench.sv
`timescale 1ns/100ps
module dual_bank_intc_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [39:0] lvl = '0;
  logic wrEn = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irqCpu0, irqCpu1, topValid;
  logic [5:0] topIdx;

  logic [39:0] mdlMask = '0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    bit isRead;
    logic [31:0] exp;
    string tag;
  } item_t;
  item_t sbQ[$];

  always #2.5 clk = ~clk;

  dual_bank_intc u_dual_bank_intc (
    .clk(clk), .rstN(rstN), .srcLevel(lvl), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqCpu0(irqCpu0), .irqCpu1(irqCpu1),
    .topIdx(topIdx), .topValid(topValid)
  );

  // bench model: pairs 3->35 and 10->38
  localparam logic [39:0] SHADOWS = (40'b1 << 35) | (40'b1 << 38);

  function automatic logic [39:0] modelPend();
    logic [39:0] p;
    for (int i = 0; i < 40; i++) begin
      int src;
      src = (i == 35) ? 3 : (i == 38) ? 10 : i;
      p[i] = lvl[src] & mdlMask[i];
    end
    return p;
  endfunction

  function automatic logic [8:0] modelPorts();
    logic [39:0] p, pr;
    logic [5:0] idx;
    p = modelPend();
    pr = p & ~SHADOWS;
    idx = '0;
    for (int i = 0; i < 40; i++) if (pr[i]) idx = 6'(i);
    return {|(p & SHADOWS), |pr, |pr, idx};
  endfunction

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    if (a == 8'h04) mdlMask[31:0] = d;
    if (a == 8'h50) mdlMask[39:32] = d[7:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectRead(logic [7:0] a, logic [31:0] e, string t);
    @(negedge clk);
    addr = a;
    sbQ.push_back('{1'b1, e, t});
  endtask

  task automatic expectPorts(string t);
    @(negedge clk);
    sbQ.push_back('{1'b0, 32'(modelPorts()), t});
  endtask

  // monitor: compares queued expectations after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sbQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sbQ.pop_front();
        act = it.isRead ? rdData : 32'({irqCpu1, irqCpu0, topValid, topIdx});
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    lvl = '1;
    settle(4);
    rstN = 1'b1;
    settle(5);
    // R1: reset state with every input high
    expectRead(8'h04, 32'h0, "R1 mask lo");
    expectRead(8'h50, 32'h0, "R1 mask hi");
    expectRead(8'h08, 32'h0, "R1 pend lo");
    expectRead(8'h54, 32'h0, "R1 pend hi");
    expectPorts("R1 outputs");

    // R2 / R3 / R5 / R7 low bank
    regWrite(8'h04, 32'h0000_F0F0);
    @(negedge clk); lvl = 40'h00_0000_3C3C;
    settle(6);
    expectRead(8'h04, 32'h0000_F0F0, "R2 mask lo readback");
    expectRead(8'h08, 32'h0000_3030, "R3 pend lo gated");
    expectPorts("R5 R7 low bank idx 13");

    // R2 high bank, upper bits dropped
    regWrite(8'h50, 32'hFFFF_FF81);
    @(negedge clk); lvl[39] = 1'b1; lvl[32] = 1'b0;
    settle(6);
    expectRead(8'h50, 32'h0000_0081, "R2 mask hi upper zero");
    expectRead(8'h54, 32'h0000_0080, "R3 pend hi");
    expectPorts("R7 idx 39 across banks");

    // R6 shadow routing
    regWrite(8'h50, 32'h0000_0088);
    @(negedge clk); lvl[3] = 1'b1; lvl[35] = 1'b0; lvl[39] = 1'b0;
    settle(6);
    expectRead(8'h54, 32'h0000_0008, "R6 shadow 35 follows source 3");
    expectPorts("R6 irqCpu1 raised");
    @(negedge clk); lvl[3] = 1'b0; lvl[35] = 1'b1;
    settle(6);
    expectRead(8'h54, 32'h0000_0000, "R6 shadow input wire ignored");
    expectPorts("R6 irqCpu1 low");

    // R4 level-following: drop then raise
    @(negedge clk); lvl = '0;
    settle(6);
    expectRead(8'h08, 32'h0, "R4 pend clears on low level");
    expectPorts("R4 outputs drop");
    @(negedge clk); lvl[12] = 1'b1;
    settle(6);
    expectRead(8'h08, 32'h0000_1000, "R4 pend sets on high level");
    expectPorts("R5 single source");

    // R8 unmapped writes and reads
    regWrite(8'h0C, 32'hFFFF_FFFF);
    regWrite(8'h58, 32'hFFFF_FFFF);
    regWrite(8'h08, 32'h0000_0000);
    expectRead(8'h0C, 32'h0, "R8 unmapped read");
    expectRead(8'h04, 32'h0000_F0F0, "R8 mask lo unchanged");
    expectRead(8'h50, 32'h0000_0088, "R8 mask hi unchanged");

    // R7 priority then drop the top one
    regWrite(8'h04, 32'h0010_0020);
    regWrite(8'h50, 32'h0000_0080);
    @(negedge clk); lvl = '0; lvl[5] = 1'b1; lvl[20] = 1'b1; lvl[39] = 1'b1;
    settle(6);
    expectPorts("R7 picks 39");
    @(negedge clk); lvl[39] = 1'b0;
    settle(6);
    expectPorts("R7 falls back to 20");

    // R9 mask everything
    @(negedge clk); lvl = '1;
    regWrite(8'h04, 32'h0);
    regWrite(8'h50, 32'h0);
    settle(6);
    expectPorts("R9 all disabled");
    expectRead(8'h08, 32'h0, "R9 pend lo zero");
    expectRead(8'h54, 32'h0, "R9 pend hi zero");

    settle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule